// File: doc/BRIEF.md
# Supply-Loss Write Guard

This block sits between a host memory controller and a battery-backed 32K x 8 static memory. Three external comparators report the supply as digital flags: above the full-operation level, above the write-protect trip level, and above the battery switchover level. The flags pass through two-flop synchronizers. A five-state machine then decides whether host strobes may reach the array, whether the array runs from the backup cell, and whether the backup cell is connected at all.

Host chip enable, write enable and output enable are active low. In the powered state they pass straight through to the memory strobes. In every other state the memory strobes are forced inactive and the data drivers are released to high impedance. A protect decision takes effect on the cycle the state changes, even if a host write is in progress. Such an abort is recorded in a sticky flag. The backup cell stays disconnected until the supply is first seen above the trip level. After every return of power, access stays locked out for a parameterized number of clock cycles. The full-operation level comes from one of two comparators, chosen by a tolerance parameter.

Top module: `supply_guard`

## Requirements
- R1: While reset is asserted, guardState is 0 (sealed), memCeN, memWeN and memOeN are 1, and dqOe, battSel, battEn and wrAbort are 0.
- R2: Each raw supply flag passes through two synchronizer flops, so a flag change set up before clock edge N first affects guardState after edge N+2.
- R3: battEn is 0 until the state first leaves sealed, which happens when the synchronized trip flag is high. battEn then stays 1 until reset, and the state never returns to sealed. While sealed, battSel stays 0 whatever the switchover flag does.
- R4: In every state except powered (1), memCeN and memWeN are 1, memOeN is 1 and dqOe is 0, whatever the host inputs are. A synchronized trip flag low in powered moves the state to protected (2).
- R5: A synchronized switchover flag low in powered, protected or recovering moves the state to on-battery (3), where battSel is 1. When the flag returns high, the state goes to recovering (4) if the trip flag is high, otherwise to protected, and battSel returns to 0.
- R6: Each visit to recovering lasts at least REC_CYCLES clock cycles. It ends in powered only when the selected full-operation flag is high. A low trip flag during recovering goes to protected.
- R7: With TIGHT_TOL=1 the full-operation flag is opHiRaw. With TIGHT_TOL=0 it is opLoRaw.
- R8: In powered, memCeN equals ceN, memWeN equals weN OR ceN, and dqOe is 1 exactly when ceN=0, oeN=0 and weN=1. memOeN is always the inverse of dqOe.
- R9: If the state leaves powered while ceN=0 and weN=0, memWeN is 1 in the first cycle of the new state, and wrAbort becomes 1 in that same cycle and stays 1 until reset.
- R10: guardState encodes sealed=0, powered=1, protected=2, on-battery=3, recovering=4. No other value appears. In protected, a high trip flag with a high switchover flag moves the state to recovering.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| opHiRaw | input | 1 | Supply above the tight-tolerance full-operation level |
| opLoRaw | input | 1 | Supply above the wide-tolerance full-operation level |
| tripRaw | input | 1 | Supply above the write-protect trip level |
| swRaw | input | 1 | Supply above the battery switchover level |
| ceN | input | 1 | Host chip enable, active low |
| weN | input | 1 | Host write enable, active low |
| oeN | input | 1 | Host output enable, active low |
| memCeN | output | 1 | Gated chip enable to the array |
| memWeN | output | 1 | Gated write enable to the array |
| memOeN | output | 1 | Gated output enable to the array |
| dqOe | output | 1 | Data driver enable, 0 releases the data bus |
| battSel | output | 1 | Array powered from the backup cell |
| battEn | output | 1 | Backup cell connected (freshness seal broken) |
| wrAbort | output | 1 | Sticky: a host write was cut off by a protect decision |
| guardState | output | 3 | Current state encoding |

## Verification
Two functions can land in the same cycle: the host write strobe reaching the array, and the protect decision that has to cut it off. The bench holds ceN and weN low while it drops the trip flag. It checks that the state holds for exactly two edges and changes on the third. On that same cycle, memWeN must already be high and wrAbort must already be set. A behavioural reference model is compared with every output on every clock. It also covers the switchover-versus-trip priority when both flags move together.

// File: rtl/supply_guard_pkg.sv
package supply_guard_pkg;

  typedef enum logic [2:0] {
    ST_SEALED  = 3'd0,
    ST_POWERED = 3'd1,
    ST_PROTECT = 3'd2,
    ST_BATTERY = 3'd3,
    ST_RECOVER = 3'd4
  } guardState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic allowAccess;
    logic onBattery;
    logic sealOpen;
  } guardCtl_t;

  localparam int FLAG_SW   = 0;
  localparam int FLAG_TRIP = 1;
  localparam int FLAG_OK   = 2;
  localparam int NUM_FLAGS = 3;

endpackage

// File: rtl/supply_guard_ctrl.sv
module supply_guard_ctrl
  import supply_guard_pkg::*;
#(
  parameter bit TIGHT_TOL   = 1'b1,
  parameter int REC_CYCLES  = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        opHiRaw,
  input  logic        opLoRaw,
  input  logic        tripRaw,
  input  logic        swRaw,
  input  logic        ceN,
  input  logic        weN,
  output guardCtl_t   ctl,
  output logic        wrAbort,
  output guardState_t state
);

  localparam int CNT_W = $clog2(REC_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(REC_CYCLES - 1);

  logic [NUM_FLAGS-1:0] rawFlags;
  logic [NUM_FLAGS-1:0] syncPipe [SYNC_STAGES];
  logic [NUM_FLAGS-1:0] flags;

  assign rawFlags[FLAG_OK]   = TIGHT_TOL ? opHiRaw : opLoRaw;
  assign rawFlags[FLAG_TRIP] = tripRaw;
  assign rawFlags[FLAG_SW]   = swRaw;

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncPipe[s] <= '0;
      else if (s == 0) syncPipe[s] <= rawFlags;
      else syncPipe[s] <= syncPipe[(s == 0) ? 0 : s - 1];
    end
  end

  assign flags = syncPipe[SYNC_STAGES-1];

  logic okF, tripF, swF;
  assign okF   = flags[FLAG_OK];
  assign tripF = flags[FLAG_TRIP];
  assign swF   = flags[FLAG_SW];

  logic [CNT_W-1:0] recCnt;
  logic             recDone;
  guardState_t      nextState;
  logic             sealOpen;

  assign recDone = (recCnt == CNT_LAST);

  always_comb begin
    nextState = state;
    unique case (state)
      ST_SEALED:  if (tripF) nextState = ST_RECOVER;
      ST_POWERED: begin
        if (!swF)        nextState = ST_BATTERY;
        else if (!tripF) nextState = ST_PROTECT;
      end
      ST_PROTECT: begin
        if (!swF)       nextState = ST_BATTERY;
        else if (tripF) nextState = ST_RECOVER;
      end
      ST_BATTERY: if (swF) nextState = tripF ? ST_RECOVER : ST_PROTECT;
      ST_RECOVER: begin
        if (!swF)                nextState = ST_BATTERY;
        else if (!tripF)         nextState = ST_PROTECT;
        else if (recDone && okF) nextState = ST_POWERED;
      end
      default: nextState = ST_PROTECT;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_SEALED;
      recCnt   <= '0;
      sealOpen <= 1'b0;
      wrAbort  <= 1'b0;
    end else begin
      state <= nextState;
      if (state != ST_RECOVER) recCnt <= '0;
      else if (!recDone)       recCnt <= recCnt + 1'b1;
      if (nextState != ST_SEALED) sealOpen <= 1'b1;
      if (state == ST_POWERED && nextState != ST_POWERED && !ceN && !weN)
        wrAbort <= 1'b1;
    end
  end

  assign ctl.allowAccess = (state == ST_POWERED);
  assign ctl.onBattery   = (state == ST_BATTERY);
  assign ctl.sealOpen    = sealOpen;

endmodule

// File: rtl/supply_guard_path.sv
module supply_guard_path
  import supply_guard_pkg::*;
(
  input  guardCtl_t ctl,
  input  logic      ceN,
  input  logic      weN,
  input  logic      oeN,
  output logic      memCeN,
  output logic      memWeN,
  output logic      memOeN,
  output logic      dqOe,
  output logic      battSel,
  output logic      battEn
);

  logic selected;
  assign selected = ctl.allowAccess & ~ceN;

  assign memCeN  = ~selected;
  assign memWeN  = ~(selected & ~weN);
  assign dqOe    = selected & ~oeN & weN;
  assign memOeN  = ~dqOe;
  assign battSel = ctl.onBattery & ctl.sealOpen;
  assign battEn  = ctl.sealOpen;

endmodule

// File: rtl/supply_guard.sv
module supply_guard
  import supply_guard_pkg::*;
#(
  parameter bit TIGHT_TOL  = 1'b1,
  parameter int REC_CYCLES = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       opHiRaw,
  input  logic       opLoRaw,
  input  logic       tripRaw,
  input  logic       swRaw,
  input  logic       ceN,
  input  logic       weN,
  input  logic       oeN,
  output logic       memCeN,
  output logic       memWeN,
  output logic       memOeN,
  output logic       dqOe,
  output logic       battSel,
  output logic       battEn,
  output logic       wrAbort,
  output logic [2:0] guardState
);

  guardCtl_t   ctl;
  guardState_t state;

  supply_guard_ctrl #(
    .TIGHT_TOL  (TIGHT_TOL),
    .REC_CYCLES (REC_CYCLES),
    .SYNC_STAGES(2)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .opHiRaw(opHiRaw),
    .opLoRaw(opLoRaw),
    .tripRaw(tripRaw),
    .swRaw  (swRaw),
    .ceN    (ceN),
    .weN    (weN),
    .ctl    (ctl),
    .wrAbort(wrAbort),
    .state  (state)
  );

  supply_guard_path u_path (
    .ctl    (ctl),
    .ceN    (ceN),
    .weN    (weN),
    .oeN    (oeN),
    .memCeN (memCeN),
    .memWeN (memWeN),
    .memOeN (memOeN),
    .dqOe   (dqOe),
    .battSel(battSel),
    .battEn (battEn)
  );

  assign guardState = state;

endmodule

// File: rtl/supply_guard_chk.sv
module supply_guard_chk #(
  parameter int REC_CYCLES = 64
) (
  input logic       clk,
  input logic       rstN,
  input logic       memCeN,
  input logic       memWeN,
  input logic       dqOe,
  input logic       battSel,
  input logic       battEn,
  input logic       wrAbort,
  input logic [2:0] guardState
);

  int recRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) recRun <= 0;
    else if (guardState == 3'd4) recRun <= (recRun < REC_CYCLES) ? recRun + 1 : recRun;
    else recRun <= 0;
  end

  AST_LOCKED_OUT: assert property (@(posedge clk) disable iff (!rstN)
    guardState != 3'd1 |-> (memCeN && memWeN && !dqOe)); // R4

  AST_SEAL_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    battEn |=> battEn); // R3

  AST_NO_RESEAL: assert property (@(posedge clk) disable iff (!rstN)
    guardState != 3'd0 |=> guardState != 3'd0); // R3

  AST_BATT_NEEDS_SEAL: assert property (@(posedge clk) disable iff (!rstN)
    battSel |-> battEn); // R3

  AST_ABORT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    wrAbort |=> wrAbort); // R9

  AST_RECOVER_SPAN: assert property (@(posedge clk) disable iff (!rstN)
    (guardState == 3'd1 && $past(guardState) == 3'd4) |-> recRun >= REC_CYCLES); // R6

  AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    guardState <= 3'd4); // R10

endmodule

bind supply_guard supply_guard_chk #(.REC_CYCLES(REC_CYCLES)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .memCeN    (memCeN),
  .memWeN    (memWeN),
  .dqOe      (dqOe),
  .battSel   (battSel),
  .battEn    (battEn),
  .wrAbort   (wrAbort),
  .guardState(guardState)
);

// File: tb/supply_guard_bench.sv
`timescale 1ns/1ps
module supply_guard_bench;

  localparam int REC = 64;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic opHiRaw = 0, opLoRaw = 0, tripRaw = 0, swRaw = 0;
  logic ceN = 1, weN = 1, oeN = 1;

  logic memCeN, memWeN, memOeN, dqOe, battSel, battEn, wrAbort;
  logic [2:0] guardState;
  logic wCeN, wWeN, wOeN, wDq, wBs, wBe, wAb;
  logic [2:0] wideState;

  int checks = 0;
  int errors = 0;
  bit run = 0;
  bit finished = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  supply_guard #(.TIGHT_TOL(1'b1), .REC_CYCLES(REC)) u_supply_guard (
    .clk(clk), .rstN(rstN), .opHiRaw(opHiRaw), .opLoRaw(opLoRaw),
    .tripRaw(tripRaw), .swRaw(swRaw), .ceN(ceN), .weN(weN), .oeN(oeN),
    .memCeN(memCeN), .memWeN(memWeN), .memOeN(memOeN), .dqOe(dqOe),
    .battSel(battSel), .battEn(battEn), .wrAbort(wrAbort), .guardState(guardState));

  supply_guard #(.TIGHT_TOL(1'b0), .REC_CYCLES(REC)) u_supply_guard_wide (
    .clk(clk), .rstN(rstN), .opHiRaw(opHiRaw), .opLoRaw(opLoRaw),
    .tripRaw(tripRaw), .swRaw(swRaw), .ceN(ceN), .weN(weN), .oeN(oeN),
    .memCeN(wCeN), .memWeN(wWeN), .memOeN(wOeN), .dqOe(wDq),
    .battSel(wBs), .battEn(wBe), .wrAbort(wAb), .guardState(wideState));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // reference model: flags delayed two clocks, then state decided by the requirements
  logic [3:0] d1, d2; // {opHi, opLo, trip, sw}
  int mState [2];
  int mCnt [2];
  bit mSeal [2];
  bit mAbort;

  function automatic int nextOf(int st, bit ok, bit tr, bit sw, bit done);
    if (st == 0) return tr ? 4 : 0;
    if (st == 3) return sw ? (tr ? 4 : 2) : 3;
    if (!sw) return 3;
    if (st == 1) return tr ? 1 : 2;
    if (st == 2) return tr ? 4 : 2;
    if (!tr) return 2;
    return (done && ok) ? 1 : 4;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      d1 <= '0; d2 <= '0; mAbort <= 0;
      for (int k = 0; k < 2; k++) begin
        mState[k] <= 0; mCnt[k] <= 0; mSeal[k] <= 0;
      end
    end else begin
      d1 <= {opHiRaw, opLoRaw, tripRaw, swRaw};
      d2 <= d1;
      for (int k = 0; k < 2; k++) begin
        int n;
        n = nextOf(mState[k], (k == 0) ? d2[3] : d2[2], d2[1], d2[0], mCnt[k] == REC - 1);
        if (k == 0 && mState[0] == 1 && n != 1 && !ceN && !weN) mAbort <= 1;
        if (mState[k] == 4) mCnt[k] <= (mCnt[k] == REC - 1) ? mCnt[k] : mCnt[k] + 1;
        else mCnt[k] <= 0;
        if (n != 0) mSeal[k] <= 1;
        mState[k] <= n;
      end
    end
  end

  always @(negedge clk) begin
    if (run && !finished) begin
      bit allow, eDq;
      allow = (mState[0] == 1);
      eDq = allow && !ceN && !oeN && weN;
      chk("R2 R10 state", guardState, mState[0]);
      chk("R7 wide state", wideState, mState[1]);
      chk(allow ? "R8 memCeN" : "R4 memCeN", memCeN, ceN | !allow);
      chk(allow ? "R8 memWeN" : "R4 memWeN", memWeN, weN | ceN | !allow);
      chk(allow ? "R8 dqOe" : "R4 dqOe", dqOe, eDq);
      chk("R8 memOeN", memOeN, !eDq);
      chk("R5 battSel", battSel, mState[0] == 3 && mSeal[0]);
      chk("R3 battEn", battEn, mSeal[0]);
      chk("R9 wrAbort", wrAbort, mAbort);
    end
  end

  task automatic wt(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic host(input bit c, input bit w, input bit o);
    ceN = c; weN = w; oeN = o;
  endtask

  task automatic finish_run();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !finished) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d cycles", cycles, 20000);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1 state", guardState, 0);
    chk("R1 memCeN", memCeN, 1);
    chk("R1 memWeN", memWeN, 1);
    chk("R1 memOeN", memOeN, 1);
    chk("R1 dqOe", dqOe, 0);
    chk("R1 battSel", battSel, 0);
    chk("R1 battEn", battEn, 0);
    chk("R1 wrAbort", wrAbort, 0);
    @(posedge clk); #1;
    rstN = 1; run = 1;

    // R3: sealed, switchover flag toggling, host active
    host(0, 0, 0);
    swRaw = 1; wt(6);
    swRaw = 0; wt(6);
    chk("R3 sealed battSel", battSel, 0);
    chk("R3 sealed battEn", battEn, 0);
    host(1, 1, 1);

    // R7: only the wide full-operation flag high
    swRaw = 1; tripRaw = 1; opLoRaw = 1; wt(REC + 12);
    chk("R7 tight still recovering", guardState, 4);
    chk("R7 wide powered", wideState, 1);
    chk("R3 seal broken", battEn, 1);
    opHiRaw = 1; wt(5);
    chk("R6 tight powered", guardState, 1);

    // R8: host patterns in powered
    host(0, 1, 0); wt(2);
    host(0, 0, 1); wt(2);
    host(1, 0, 0); wt(2);
    host(0, 0, 0); wt(2);
    host(0, 1, 1); wt(2);

    // R9 and R2: protect during a write
    host(0, 0, 1);
    tripRaw = 0; opHiRaw = 0; opLoRaw = 0;
    wt(2);
    chk("R2 state held two edges", guardState, 1);
    wt(1);
    chk("R2 protect on third edge", guardState, 2);
    chk("R9 memWeN cut", memWeN, 1);
    chk("R9 abort flagged", wrAbort, 1);
    host(0, 1, 0); wt(3);
    host(1, 1, 1); wt(2);

    // R5: switchover down and up
    swRaw = 0; wt(5);
    chk("R5 on battery", battSel, 1);
    swRaw = 1; tripRaw = 1; opHiRaw = 1; opLoRaw = 1; wt(5);
    chk("R5 back to recovering", guardState, 4);
    tripRaw = 0; wt(5);
    chk("R6 trip low in recovery", guardState, 2);
    tripRaw = 1; wt(REC + 8);
    chk("R6 powered again", guardState, 1);
    chk("R9 abort still set", wrAbort, 1);

    // R5: switchover and trip drop together, then switchover returns alone
    swRaw = 0; tripRaw = 0; wt(5);
    chk("R5 battery has priority", guardState, 3);
    swRaw = 1; wt(5);
    chk("R5 return to protected", guardState, 2);
    chk("R5 battSel released", battSel, 0);
    wt(2);
    finish_run();
  end

endmodule